// File: doc/BRIEF.md
# Periodic Lane Alignment Marker Inserter

This block sits in a 66-bit block datapath and carries one block per clock. It breaks the stream on a fixed schedule to emit a group of alignment markers, one for each lane. It sends the markers for lanes 0 to p-1 back to back and then passes p·G ordinary blocks from upstream. G is 16383 by default, which gives a repeat period of p·(G+1) blocks.

While the markers go out, the upstream source is held off through its ready signal, so no block is lost or reordered. A receiver recognises a marker by six fixed octets that are specific to its lane. A marker also carries a running parity octet for its lane and the complement of that octet.

Lanes are taken round-robin. The k-th block sent after reset belongs to lane k mod p, so the parity of each lane is kept separately. Idle cycles upstream do not advance the schedule.

Top module: `am_inserter`

## Requirements
- R1: After reset the first p output blocks are the markers for lanes 0,1,…,p-1 in that order, and their parity octet is 8'h00 (complement 8'hFF).
- R2: Output blocks repeat a fixed pattern: p markers on p consecutive cycles, then exactly p·GAP transferred upstream blocks, then the next marker group.
- R3: A marker has `blk[65:64]` = 2'b10. Payload octet k (k = 1..8) is `blk[8k-1:8k-8]`. Octets 1, 2, 3, 5, 6 and 7 are ID bytes 0..5 of that lane. ID byte n of lane L is `MARKER_IDS[48L+8n +: 8]`.
- R4: Octet 4 of the marker for lane L is the even parity, per bit, of all output blocks of lane L since that lane's previous marker. This includes the previous marker and excludes the current one. Parity bit i is the XOR of the block bits at positions j where j mod 8 = i, for j = 0..65.
- R5: Octet 8 of every marker is the bitwise complement of octet 4.
- R6: `in_ready` is low exactly when the next output slot is a marker. During marker emission `out_valid` is high on every cycle.
- R7: Upstream blocks appear at the output unchanged, in order, without loss or duplication, one cycle after transfer.
- R8: While `rst_n` is low, `out_valid` and `in_ready` are low.
- R9: A cycle without `in_valid` outside a marker group produces no output and does not advance the lane or gap position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream block present |
| in_ready | output | 1 | Block accepted this cycle when high with in_valid |
| in_block | input | 66 | Upstream block, sync header in bits 65:64 |
| out_valid | output | 1 | Output block present |
| out_block | output | 66 | Output block (marker or passed-through block) |

## Verification
The assertions assume that upstream keeps `in_block` meaningful only while `in_valid` is high. They also assume that no downstream stall exists, since the output has no ready. The bench drives blocks only through the valid/ready handshake and holds a block until it is accepted. It inserts random idle cycles so that the schedule is seen to pause, not to slip. Upstream blocks include all-zero and all-one patterns and blocks carrying the marker sync header. This checks that markers are identified by schedule position and not by content.

// File: rtl/am_pkg.sv
package am_pkg;
  localparam int BLK_W     = 66;
  localparam int MAX_LANES = 32;
  localparam logic [1:0] SYNC_CTRL = 2'b10;

  typedef logic [BLK_W-1:0] blk_t;

  function automatic logic [7:0] parity_fold(input blk_t b);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < BLK_W; j++) r[j % 8] = r[j % 8] ^ b[j];
    return r;
  endfunction

  function automatic logic [MAX_LANES*48-1:0] default_ids(input int lanes);
    logic [MAX_LANES*48-1:0] v;
    v = '0;
    for (int l = 0; l < MAX_LANES; l++)
      for (int n = 0; n < 6; n++)
        if (l < lanes) v[48*l+8*n +: 8] = 8'(8'hC1 ^ (l * 8'd37) ^ (n * 8'd91));
    return v;
  endfunction
endpackage

// File: rtl/am_sched.sv
module am_sched #(
  parameter int LANES = 4,
  parameter int GAP   = 16383,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TOTAL = LANES * GAP,
  localparam int GW   = $clog2(TOTAL) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          mk_phase,
  output logic          beat,
  output logic [LW-1:0] lane
);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
  localparam logic [GW-1:0] LAST_GAP  = GW'(TOTAL - 1);

  logic          mk_d;
  logic [LW-1:0] lane_d;
  logic [GW-1:0] gap_q, gap_d;

  assign beat = mk_phase | in_valid;

  always_comb begin
    mk_d   = mk_phase;
    lane_d = lane;
    gap_d  = gap_q;
    if (beat) begin
      lane_d = (lane == LAST_LANE) ? '0 : lane + 1'b1;
      if (mk_phase) begin
        if (lane == LAST_LANE) begin
          mk_d  = 1'b0;
          gap_d = '0;
        end
      end else if (gap_q == LAST_GAP) begin
        mk_d  = 1'b1;
        gap_d = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_phase <= 1'b1;
      lane     <= '0;
      gap_q    <= '0;
    end else if (beat) begin
      mk_phase <= mk_d;
      lane     <= lane_d;
      gap_q    <= gap_d;
    end
  end

  logic [LW:0] mk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mk_run <= '0;
    else        mk_run <= mk_phase ? mk_run + 1'b1 : '0;
  end

  a_r2_group_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mk_phase) |-> mk_run == (LW+1)'(LANES));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_phase && !in_valid) |=> ($stable(gap_q) && $stable(lane) && !mk_phase));

  a_r1_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    lane <= LAST_LANE);
endmodule

// File: rtl/am_parity_bank.sv
module am_parity_bank #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          is_marker,
  input  logic [LW-1:0] lane,
  input  am_pkg::blk_t  blk,
  output logic [7:0]    lane_par
);
  logic [7:0] acc [LANES];
  logic [7:0] fold;

  assign fold     = am_pkg::parity_fold(blk);
  assign lane_par = acc[lane];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] acc_d;
    assign hit   = beat && (lane == LW'(g));
    assign acc_d = is_marker ? fold : (acc[g] ^ fold);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc[g] <= '0;
      else if (hit) acc[g] <= acc_d;
    end
  end

  a_r4_marker_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && is_marker) |=> acc[$past(lane)] == $past(fold));
endmodule

// File: rtl/am_marker_fmt.sv
module am_marker_fmt #(
  parameter int LANES = 4,
  parameter logic [LANES*48-1:0] MARKER_IDS = '0,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LW-1:0] lane,
  input  logic [7:0]    par,
  output am_pkg::blk_t  marker
);
  logic [47:0] ids;

  always_comb begin
    ids = '0;
    for (int l = 0; l < LANES; l++)
      if (lane == LW'(l)) ids = MARKER_IDS[48*l +: 48];
  end

  assign marker = {am_pkg::SYNC_CTRL,
                   ~par, ids[47:24], par, ids[23:0]};
endmodule

// File: rtl/am_inserter.sv
module am_inserter #(
  parameter int LANES = 4,
  parameter int GAP   = 16383,
  parameter logic [LANES*48-1:0] MARKER_IDS = (LANES*48)'(am_pkg::default_ids(LANES))
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [65:0] in_block,
  output logic        out_valid,
  output logic [65:0] out_block
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic          mk_phase, beat;
  logic [LW-1:0] lane;
  logic [7:0]    lane_par;
  am_pkg::blk_t  marker, next_blk;

  am_sched #(.LANES(LANES), .GAP(GAP)) u_sched (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid),
    .mk_phase(mk_phase), .beat(beat), .lane(lane));

  am_marker_fmt #(.LANES(LANES), .MARKER_IDS(MARKER_IDS)) u_fmt (
    .lane(lane), .par(lane_par), .marker(marker));

  assign next_blk = mk_phase ? marker : in_block;

  am_parity_bank #(.LANES(LANES)) u_par (
    .clk(clk), .rst_n(rst_s), .beat(beat), .is_marker(mk_phase),
    .lane(lane), .blk(next_blk), .lane_par(lane_par));

  assign in_ready = rst_s && !mk_phase;

  logic out_is_mk;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid <= 1'b0;
      out_is_mk <= 1'b0;
    end else begin
      out_valid <= beat;
      out_is_mk <= mk_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)    out_block <= '0;
    else if (beat) out_block <= next_blk;
  end

  a_r3_sync_hdr: assert property (@(posedge clk) disable iff (!rst_s)
    out_is_mk |-> out_block[65:64] == am_pkg::SYNC_CTRL);

  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_s)
    out_is_mk |-> out_block[63:56] == ~out_block[31:24]);

  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready) |=> (out_valid && !out_is_mk && out_block == $past(in_block)));

  a_r6_stall_fills: assert property (@(posedge clk) disable iff (!rst_s)
    !in_ready |=> out_valid);

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !in_ready));
endmodule

// File: tb/am_inserter_test.sv
`timescale 1ns/1ps
module am_inserter_test;
  localparam int LANES = 4;
  localparam int GAP   = 3;
  localparam int PER   = LANES * (GAP + 1);
  localparam int NBLK  = 300;

  function automatic logic [7:0] id_byte(input int l, input int n);
    return 8'(8'h30 + l * 16 + n * 3);
  endfunction

  function automatic logic [LANES*48-1:0] make_ids();
    logic [LANES*48-1:0] v;
    for (int l = 0; l < LANES; l++)
      for (int n = 0; n < 6; n++) v[48*l+8*n +: 8] = id_byte(l, n);
    return v;
  endfunction

  function automatic logic [7:0] fold(input logic [65:0] b);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < 66; j++) r[j % 8] ^= b[j];
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [65:0] in_block = '0;
  logic in_ready, out_valid;
  logic [65:0] out_block;

  always #2.5 clk = ~clk;

  am_inserter #(.LANES(LANES), .GAP(GAP), .MARKER_IDS(make_ids())) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_block(out_block));

  int checks = 0;
  int errors = 0;
  logic [65:0] expq[$];
  logic [7:0] bip [LANES];
  int pos = 0;
  int groups = 0;
  bit started = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send(input logic [65:0] b);
    bit acc;
    acc = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_block = b;
    while (!acc) begin
      #1;
      if (in_ready) begin
        expq.push_back(b);
        acc = 1;
      end
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: scoreboard against model of schedule, markers and parity
  always @(negedge clk) begin
    if (started && !done) begin
      logic [65:0] exp;
      int l;
      l = pos % LANES;
      if (out_valid) begin
        if (pos < LANES) begin
          exp = {2'b10, ~bip[l], id_byte(l,5), id_byte(l,4), id_byte(l,3),
                 bip[l], id_byte(l,2), id_byte(l,1), id_byte(l,0)};
          if (groups == 0) check(out_block == exp, "R1", out_block, exp);
          else             check(out_block == exp, "R3/R4/R5", out_block, exp);
          bip[l] = fold(exp);
          if (pos == LANES - 1) groups++;
        end else begin
          if (expq.size() == 0) begin
            check(0, "R7", out_block, '0);
            exp = out_block;
          end else begin
            exp = expq.pop_front();
            check(out_block == exp, "R7", out_block, exp);
          end
          bip[l] = bip[l] ^ fold(exp);
        end
        pos = (pos + 1) % PER;
      end else if (pos < LANES && groups > 0) begin
        check(0, "R2", 66'(pos), 66'(LANES));
      end
      check(in_ready == (pos >= LANES), "R6 R9", 66'(in_ready), 66'(pos >= LANES));
    end
  end

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    logic [65:0] b;
    for (int l = 0; l < LANES; l++) bip[l] = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready, "R8", {in_ready, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    for (int k = 0; k < NBLK; k++) begin
      case (k % 5)
        0: b = {2'b01, 64'h0};
        1: b = {2'b01, {64{1'b1}}};
        2: b = {2'b10, 32'h1E00_0000, $urandom()};
        default: b = {2'b01, $urandom(), $urandom()};
      endcase
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
      send(b);
    end
    repeat (2 * PER) @(negedge clk);
    check(expq.size() == 0, "R7", 66'(expq.size()), '0);
    check(groups >= 3, "R2", 66'(groups), 66'd3);
    done = 1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!out_valid && !in_ready, "R8", {in_ready, out_valid}, '0);
    finish_run();
  end
endmodule